// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer

This block turns a virtual address into a physical address. It holds a small set of recently used page mappings. Every mapping is searched at the same time, and each one is tagged with the identifier of the process that owns it. When a valid mapping matches both the page number and the current process identifier, the physical address is returned on the next clock edge and memory is not touched.

When no mapping matches, the block makes exactly one read of a flat page table in memory and waits for the reply. The table's start address comes from a base register, and its size in entries comes from a length register. A table entry whose present flag is set is written into the buffer and completes the translation. An entry without that flag produces a protection fault. A page number at or beyond the table length faults at once, with no memory read.

The block handles one request at a time. It holds its response until the requester acknowledges it. A separate input clears every mapping that belongs to one process in a single cycle.

Top module: `tlb_xlate`

## Requirements
- R1: When the requested page number and `cfg_asid` match a valid stored mapping, `rsp_valid` rises on the edge that follows acceptance (one cycle), `mem_req` stays low, and `rsp_paddr` = {stored frame, page offset} with `rsp_fault` = 0.
- R2: On a miss, the block raises `mem_req` with `mem_addr` = `cfg_pt_base` + page number. It holds both steady until `mem_rvalid` is seen, issues no further read, and shows the response one cycle after `mem_rvalid`.
- R3: A table word is read as follows: bit PFN_W is the present flag and bits PFN_W-1:0 are the frame number. A present word completes the request with `rsp_paddr` = {frame, offset}, and the mapping is stored, so a repeat of the same request hits.
- R4: A table word whose present flag is 0 gives `rsp_fault` = 1 and stores nothing, so the same request misses again and reads memory again.
- R5: A page number greater than or equal to `cfg_pt_len` gives `rsp_fault` = 1 one cycle after acceptance, with no memory read.
- R6: A stored mapping hits only for the process identifier it was filled under. The same page under another identifier misses.
- R7: A fill goes to the lowest-numbered empty slot. When every slot holds a mapping, the victim is taken from a rotating pointer that starts at slot 0 and advances by one after each such replacement.
- R8: A cycle with `inv_en` high clears every mapping tagged `inv_asid`. Mappings of other processes stay valid.
- R9: `req_ready` is high only while idle. Once `rsp_valid` is high, it stays high with `rsp_paddr` and `rsp_fault` unchanged until a cycle with `rsp_ack` high.
- R10: After reset, `req_ready` = 1, `rsp_valid` = 0, `mem_req` = 0, and no mapping is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_asid | input | ASID_W | Identifier of the running process |
| cfg_pt_base | input | MEM_AW | Memory address of page-table entry 0 |
| cfg_pt_len | input | VPN_W+1 | Number of entries in the page table |
| inv_en | input | 1 | Clear mappings of one process this cycle |
| inv_asid | input | ASID_W | Process whose mappings are cleared |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_vaddr | input | VPN_W+OFF_W | Virtual address: page number above, offset below |
| rsp_valid | output | 1 | Translation result present |
| rsp_ack | input | 1 | Requester takes the result |
| rsp_paddr | output | PFN_W+OFF_W | Physical address (zero when faulting) |
| rsp_fault | output | 1 | Protection fault instead of a translation |
| mem_req | output | 1 | Page-table read pending |
| mem_addr | output | MEM_AW | Page-table word address |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | PFN_W+1 | Page-table word: present flag above the frame number |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that the response and the pending read hold steady until they are taken, that a length fault answers in one cycle without touching memory, that a lookup hit answers in one cycle without a fault, and that an absent table word always ends in a fault. Only the bench's scenarios can show the things that depend on what the buffer contains. These are whether a request hits or misses, which slot a fill replaces under the empty-first and rotating policy, that a mapping is kept apart by process identifier, and that a clear by process removes exactly the right mappings.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

   typedef enum logic [1:0] {
      XL_IDLE  = 2'd0,
      XL_FETCH = 2'd1,
      XL_RESP  = 2'd2
   } xl_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 8,
   parameter int PFN_W   = 8,
   parameter int ASID_W  = 4,
   parameter int IDX_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [VPN_W-1:0]    lk_vpn,
   input  logic [ASID_W-1:0]   lk_asid,
   output logic                lk_hit,
   output logic [PFN_W-1:0]    lk_pfn,
   input  logic                fill_en,
   input  logic [IDX_W-1:0]    fill_idx,
   input  logic [VPN_W-1:0]    fill_vpn,
   input  logic [ASID_W-1:0]   fill_asid,
   input  logic [PFN_W-1:0]    fill_pfn,
   input  logic                inv_en,
   input  logic [ASID_W-1:0]   inv_asid,
   output logic [ENTRIES-1:0]  valid_vec
);

   logic [ENTRIES-1:0] vld_r;
   logic [VPN_W-1:0]   vpn_r  [ENTRIES];
   logic [ASID_W-1:0]  asid_r [ENTRIES];
   logic [PFN_W-1:0]   pfn_r  [ENTRIES];
   logic [ENTRIES-1:0] match;

   // storage: a fill owns its slot; a clear by process drops the others
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) begin
            vld_r[e]  <= 1'b0;
            vpn_r[e]  <= '0;
            asid_r[e] <= '0;
            pfn_r[e]  <= '0;
         end
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (fill_en && (fill_idx == IDX_W'(e))) begin
               vld_r[e]  <= 1'b1;
               vpn_r[e]  <= fill_vpn;
               asid_r[e] <= fill_asid;
               pfn_r[e]  <= fill_pfn;
            end else if (inv_en && (asid_r[e] == inv_asid)) begin
               vld_r[e]  <= 1'b0;
            end
         end
      end
   end

   // parallel compare, one comparator per slot
   genvar g;
   generate
      for (g = 0; g < ENTRIES; g++) begin : g_cmp
         assign match[g] = vld_r[g] && (vpn_r[g] == lk_vpn) && (asid_r[g] == lk_asid);
      end
   endgenerate

   // at most one slot matches, so an OR of masked frames selects it
   always_comb begin
      lk_pfn = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         lk_pfn = lk_pfn | (pfn_r[e] & {PFN_W{match[e]}});
      end
   end

   assign lk_hit    = |match;
   assign valid_vec = vld_r;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int ENTRIES = 4,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic               adv,
   output logic [IDX_W-1:0]   victim
);

   localparam bit POW2 = (ENTRIES == (1 << IDX_W));
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] ptr_nx;
   logic [IDX_W-1:0] free_idx;
   logic             all_valid;

   always_comb begin
      free_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!valid_vec[e]) free_idx = IDX_W'(e);
      end
   end

   assign all_valid = &valid_vec;
   assign victim    = all_valid ? ptr_q : free_idx;

   generate
      if (POW2) begin : g_wrap_free
         assign ptr_nx = ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nx = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                 ptr_q <= '0;
      else if (adv && all_valid)  ptr_q <= ptr_nx;
   end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_xlate_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 8,
   parameter int PFN_W   = 8,
   parameter int OFF_W   = 6,
   parameter int ASID_W  = 4,
   parameter int MEM_AW  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ASID_W-1:0]       cfg_asid,
   input  logic [MEM_AW-1:0]       cfg_pt_base,
   input  logic [VPN_W:0]          cfg_pt_len,
   input  logic                    inv_en,
   input  logic [ASID_W-1:0]       inv_asid,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [VPN_W+OFF_W-1:0]  req_vaddr,
   output logic                    rsp_valid,
   input  logic                    rsp_ack,
   output logic [PFN_W+OFF_W-1:0]  rsp_paddr,
   output logic                    rsp_fault,
   output logic                    mem_req,
   output logic [MEM_AW-1:0]       mem_addr,
   input  logic                    mem_rvalid,
   input  logic [PFN_W:0]          mem_rdata
);

   localparam int IDX_W = idx_width(ENTRIES);
   localparam int PTE_W = PFN_W + 1;

   generate
      if (ENTRIES < 1)      begin : g_bad_entries $error("ENTRIES must be at least 1"); end
      if (VPN_W > MEM_AW)   begin : g_bad_aw      $error("MEM_AW must cover the page number"); end
      if (OFF_W < 1)        begin : g_bad_off     $error("OFF_W must be at least 1"); end
   endgenerate

   xl_state_e          st_q;
   logic [VPN_W-1:0]   vpn_q;
   logic [OFF_W-1:0]   off_q;
   logic [ASID_W-1:0]  asid_q;

   logic [VPN_W-1:0]   in_vpn;
   logic [OFF_W-1:0]   in_off;
   logic               len_bad;
   logic               lk_hit;
   logic [PFN_W-1:0]   lk_pfn;
   logic [ENTRIES-1:0] valid_vec;
   logic [IDX_W-1:0]   victim;
   logic               pte_present;
   logic [PFN_W-1:0]   pte_pfn;
   logic               fill_en;

   assign in_vpn      = req_vaddr[VPN_W+OFF_W-1:OFF_W];
   assign in_off      = req_vaddr[OFF_W-1:0];
   assign len_bad     = ({1'b0, in_vpn} >= cfg_pt_len);
   assign pte_present = mem_rdata[PTE_W-1];
   assign pte_pfn     = mem_rdata[PFN_W-1:0];
   assign fill_en     = (st_q == XL_FETCH) && mem_rvalid && pte_present;

   tlb_cam #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W),
      .ASID_W  (ASID_W),
      .IDX_W   (IDX_W)
   ) u_cam (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_vpn    (in_vpn),
      .lk_asid   (cfg_asid),
      .lk_hit    (lk_hit),
      .lk_pfn    (lk_pfn),
      .fill_en   (fill_en),
      .fill_idx  (victim),
      .fill_vpn  (vpn_q),
      .fill_asid (asid_q),
      .fill_pfn  (pte_pfn),
      .inv_en    (inv_en),
      .inv_asid  (inv_asid),
      .valid_vec (valid_vec)
   );

   tlb_victim #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_vec (valid_vec),
      .adv       (fill_en),
      .victim    (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= XL_IDLE;
         vpn_q     <= '0;
         off_q     <= '0;
         asid_q    <= '0;
         rsp_paddr <= '0;
         rsp_fault <= 1'b0;
      end else begin
         unique case (st_q)
            XL_IDLE: begin
               if (req_valid) begin
                  vpn_q  <= in_vpn;
                  off_q  <= in_off;
                  asid_q <= cfg_asid;
                  if (len_bad) begin
                     rsp_paddr <= '0;
                     rsp_fault <= 1'b1;
                     st_q      <= XL_RESP;
                  end else if (lk_hit) begin
                     rsp_paddr <= {lk_pfn, in_off};
                     rsp_fault <= 1'b0;
                     st_q      <= XL_RESP;
                  end else begin
                     st_q      <= XL_FETCH;
                  end
               end
            end
            XL_FETCH: begin
               if (mem_rvalid) begin
                  rsp_paddr <= pte_present ? {pte_pfn, off_q} : '0;
                  rsp_fault <= !pte_present;
                  st_q      <= XL_RESP;
               end
            end
            XL_RESP: begin
               if (rsp_ack) st_q <= XL_IDLE;
            end
            default: st_q <= XL_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == XL_IDLE);
   assign rsp_valid = (st_q == XL_RESP);
   assign mem_req   = (st_q == XL_FETCH);
   assign mem_addr  = cfg_pt_base + MEM_AW'(vpn_q);

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int VPN_W  = 8,
   parameter int PFN_W  = 8,
   parameter int OFF_W  = 6,
   parameter int MEM_AW = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_ready,
   input logic [VPN_W+OFF_W-1:0]  req_vaddr,
   input logic [VPN_W:0]          cfg_pt_len,
   input logic                    lk_hit,
   input logic                    rsp_valid,
   input logic                    rsp_ack,
   input logic [PFN_W+OFF_W-1:0]  rsp_paddr,
   input logic                    rsp_fault,
   input logic                    mem_req,
   input logic [MEM_AW-1:0]       mem_addr,
   input logic                    mem_rvalid,
   input logic [PFN_W:0]          mem_rdata
);

   logic take;
   logic past_len;
   assign take     = req_valid && req_ready;
   assign past_len = ({1'b0, req_vaddr[VPN_W+OFF_W-1:OFF_W]} >= cfg_pt_len);

   p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

   p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

   p_read_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_rvalid |=> rsp_valid && !mem_req);

   p_len_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take && past_len |=> rsp_valid && rsp_fault && !mem_req);

   p_hit_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take && !past_len && lk_hit |=> rsp_valid && !rsp_fault && !mem_req);

   p_absent_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_rvalid && !mem_rdata[PFN_W] |=> rsp_valid && rsp_fault);

endmodule

bind tlb_xlate tlb_xlate_chk #(
   .VPN_W  (VPN_W),
   .PFN_W  (PFN_W),
   .OFF_W  (OFF_W),
   .MEM_AW (MEM_AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_vaddr  (req_vaddr),
   .cfg_pt_len (cfg_pt_len),
   .lk_hit     (lk_hit),
   .rsp_valid  (rsp_valid),
   .rsp_ack    (rsp_ack),
   .rsp_paddr  (rsp_paddr),
   .rsp_fault  (rsp_fault),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid),
   .mem_rdata  (mem_rdata)
);

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;

   localparam logic [15:0] BASE = 16'h0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_asid = '0;
   logic [15:0] cfg_pt_base = BASE;
   logic [8:0]  cfg_pt_len = 9'd30;
   logic        inv_en = 1'b0;
   logic [3:0]  inv_asid = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [13:0] req_vaddr = '0;
   logic        rsp_valid;
   logic        rsp_ack = 1'b0;
   logic [13:0] rsp_paddr;
   logic        rsp_fault;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [8:0]  mem_rdata = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   tlb_xlate uut (
      .clk(clk), .rst_n(rst_n), .cfg_asid(cfg_asid), .cfg_pt_base(cfg_pt_base),
      .cfg_pt_len(cfg_pt_len), .inv_en(inv_en), .inv_asid(inv_asid),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   // page-table contents: present unless page[2:0] == 7, frame = page + 0x40
   function automatic logic [8:0] pte_of(input logic [7:0] vpn);
      return {(vpn[2:0] != 3'd7), 8'(vpn + 8'h40)};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one request from offer to acknowledge, servicing the table read
   task automatic xlate(input logic [3:0] asid, input logic [7:0] vpn, input logic [5:0] off,
                        output logic [13:0] pa, output logic flt, output int reads,
                        output int cyc);
      @(negedge clk);
      cfg_asid  = asid;
      req_vaddr = {vpn, off};
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      reads = 0;
      while (!rsp_valid && cyc < 40) begin
         if (mem_req) begin
            reads++;
            chk(mem_addr == BASE + 16'(vpn), "R2 read address", mem_addr, BASE + 16'(vpn));
            @(negedge clk);
            cyc++;
            chk(mem_req && mem_addr == BASE + 16'(vpn), "R2 read held", mem_req, 1);
            mem_rvalid = 1'b1;
            mem_rdata  = pte_of(vpn);
            @(negedge clk);
            cyc++;
            mem_rvalid = 1'b0;
            chk(rsp_valid, "R2 response after data", rsp_valid, 1);
         end else begin
            @(negedge clk);
            cyc++;
         end
      end
      pa  = rsp_paddr;
      flt = rsp_fault;
      chk(!req_ready, "R9 not ready while responding", req_ready, 0);
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa && rsp_fault == flt, "R9 response held",
          rsp_paddr, pa);
      rsp_ack = 1'b1;
      @(negedge clk);
      rsp_ack = 1'b0;
      chk(req_ready && !rsp_valid, "R9 idle after ack", req_ready, 1);
   endtask

   // expect a hit (miss=0) or a one-read miss (miss=1), with fault from the table
   task automatic expect_x(input logic [3:0] asid, input logic [7:0] vpn, input logic [5:0] off,
                           input bit miss, input string req);
      logic [13:0] pa;
      logic        flt;
      int          rd;
      int          cy;
      logic [8:0]  w;
      bit          efl;
      w   = pte_of(vpn);
      efl = miss && !w[8];
      xlate(asid, vpn, off, pa, flt, rd, cy);
      chk(rd == int'(miss), {req, " read count"}, rd, int'(miss));
      if (!miss) chk(cy == 1, {req, " R1 hit latency"}, cy, 1);
      chk(flt == efl, {req, " fault"}, flt, efl);
      if (!efl) chk(pa == {w[7:0], off}, {req, " R3 paddr"}, pa, {w[7:0], off});
   endtask

   // {asid[3:0], vpn[7:0], off[5:0], miss}
   localparam int NV = 10;
   localparam logic [18:0] VEC [NV] = '{
      {4'd1, 8'd3, 6'd5,  1'b1},   // R2 R3 first fill, slot 0
      {4'd1, 8'd3, 6'd9,  1'b0},   // R1 R3 hit
      {4'd2, 8'd3, 6'd1,  1'b1},   // R6 other process misses, slot 1
      {4'd1, 8'd4, 6'd63, 1'b1},   // slot 2
      {4'd1, 8'd4, 6'd0,  1'b0},
      {4'd2, 8'd3, 6'd7,  1'b0},   // R6 own mapping hits
      {4'd1, 8'd7, 6'd2,  1'b1},   // R4 absent word faults
      {4'd1, 8'd7, 6'd2,  1'b1},   // R4 nothing stored, reads again
      {4'd1, 8'd5, 6'd3,  1'b1},   // slot 3, buffer full
      {4'd1, 8'd3, 6'd4,  1'b0}
   };

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
      chk(rsp_valid == 1'b0, "R10 no response", rsp_valid, 0);
      chk(mem_req == 1'b0, "R10 no read", mem_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req, "R10 idle after reset", req_ready, 1);

      for (int i = 0; i < NV; i++) begin
         expect_x(VEC[i][18:15], VEC[i][14:7], VEC[i][6:1], VEC[i][0], "R1/R2 vector");
      end

      // R5: length boundary
      begin
         logic [13:0] pa;
         logic        flt;
         int          rd;
         int          cy;
         xlate(4'd1, 8'd30, 6'd1, pa, flt, rd, cy);
         chk(flt == 1'b1, "R5 page at length faults", flt, 1);
         chk(rd == 0 && cy == 1, "R5 no read, one cycle", rd, 0);
         xlate(4'd1, 8'd200, 6'd1, pa, flt, rd, cy);
         chk(flt == 1'b1 && rd == 0, "R5 far page faults", flt, 1);
      end
      expect_x(4'd1, 8'd29, 6'd2, 1'b1, "R5 last page in range");   // slot 0 (pointer 0->1)

      // R7: rotating replacement when full
      expect_x(4'd1, 8'd3, 6'd6, 1'b1, "R7 slot 0 was replaced");  // slot 1
      expect_x(4'd2, 8'd3, 6'd6, 1'b1, "R7 slot 1 was replaced");  // slot 2
      expect_x(4'd1, 8'd5, 6'd6, 1'b0, "R7 slot 3 untouched");
      expect_x(4'd1, 8'd4, 6'd6, 1'b1, "R7 slot 2 was replaced");  // slot 3

      // R8: clear all mappings of process 1
      @(negedge clk);
      inv_en   = 1'b1;
      inv_asid = 4'd1;
      @(negedge clk);
      inv_en   = 1'b0;
      expect_x(4'd2, 8'd3, 6'd8, 1'b0, "R8 other process kept");
      expect_x(4'd1, 8'd3, 6'd8, 1'b1, "R8 cleared mapping misses");
      expect_x(4'd1, 8'd4, 6'd8, 1'b1, "R8 cleared mapping misses");
      expect_x(4'd1, 8'd29, 6'd8, 1'b1, "R8 cleared mapping misses");
      // R7: empty slots are filled before the pointer victim
      expect_x(4'd2, 8'd3, 6'd9, 1'b0, "R7 empty slots preferred");
      expect_x(4'd1, 8'd3, 6'd9, 1'b0, "R7 refill kept");
      expect_x(4'd1, 8'd4, 6'd9, 1'b0, "R7 refill kept");
      expect_x(4'd1, 8'd29, 6'd9, 1'b0, "R7 refill kept");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule